// File: doc/BRIEF.md
# Inbound Request Decode Router

This block sits behind a root-port link and looks at every inbound request header once. Each header arrives as a one-cycle descriptor: a request kind (read, write, message-signalled interrupt), an address, byte enables, a virtual channel number, a no-snoop attribute and the number of the port it came from. The router compares the address against a set of programmable windows and produces one registered routing decision. The windows are the system DRAM range, the graphics aperture, a window owned by a peer root port and the south-bridge link window. The decision names a destination and a snoop flag. It also carries the possibly rewritten address and byte enables, plus an unsupported-request flag and an unsuccessful-completion flag.

Inbound and outbound sides use a valid/ready handshake. The decision appears one cycle after a descriptor is accepted and is held until it is taken. The window bounds, the DRAM top, the bus-master enable and the peer window's owning port are loaded through a small register write port.

Top module: `pcie_inbound_router`

## Requirements
- R1: A descriptor is accepted on a clock edge where inValid and inReady are both high. The decision is presented with outValid high after that same edge and stays stable until an edge where outReady is high. inReady is high whenever outValid is low or outReady is high.
- R2: With the bus-master enable (control register bit 0) clear, every request of any kind is reported with outUr high.
- R3: A request whose channel number is not 0 is reported with outUr high. Request kind 3 is also reported this way. These checks come after the bus-master check.
- R4: A request of kind 2 (interrupt message) goes to destination 4 (interrupt) with outSnoop low and outUr low, whatever the no-snoop bit and the address.
- R5: A write (kind 1) inside the aperture window goes to destination 2 (graphics) with outSnoop low, whatever the no-snoop bit. A read (kind 0) inside that window is reported with outUr high.
- R6: A write inside the peer window goes to destination 3 (peer) with outSnoop low only when its source port differs from the window's owning port. A read in the window, or a write from the owning port, is reported with outUr high.
- R7: Any request inside the south-bridge window is reported with outUr high, and this takes precedence over the peer window.
- R8: A request below the DRAM top goes to destination 1 (DRAM) with outSnoop equal to the inverse of its no-snoop bit, and with address and byte enables unchanged.
- R9: A no-snoop read that misses every window and lies at or above the DRAM top goes to destination 1 at address 000C_0000h. It has outSnoop low, outFailCpl high, and its byte enables unchanged.
- R10: A no-snoop write that misses every window and lies at or above the DRAM top goes to destination 1 at address 000C_0000h. It has outSnoop low and all byte enables zero.
- R11: A snooped request that misses every window is reported with outUr high and outFailCpl low, and its address and byte enables pass through unchanged. Every unsupported decision carries destination 0 and outSnoop low.
- R12: Overlapping conditions resolve in this order: bus-master enable, channel and kind, interrupt message, aperture, south-bridge/peer windows, DRAM and no-snoop handling.
- R13: A write with cfgWrEn high loads the register chosen by cfgSel on that edge. Selector 0 is the DRAM top and 1 is control (bit 0 bus-master enable, bits 2:1 owning port of the peer window). Selectors 2/3 are the aperture base/limit, 4/5 the peer base/limit and 6/7 the south-bridge base/limit, with inclusive limits. Decisions made after the write use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register selector |
| cfgData | input | 32 | Configuration write data |
| inValid | input | 1 | Descriptor valid |
| inReady | output | 1 | Descriptor can be accepted |
| inKind | input | 2 | 0 read, 1 write, 2 interrupt message, 3 reserved |
| inAddr | input | 32 | Request address |
| inBe | input | 4 | Request byte enables |
| inVc | input | 3 | Virtual channel number |
| inNoSnoop | input | 1 | No-snoop attribute |
| inSrcPort | input | 2 | Source root port number |
| outValid | output | 1 | Decision valid |
| outReady | input | 1 | Decision taken |
| outDest | output | 3 | 0 none, 1 DRAM, 2 graphics, 3 peer, 4 interrupt |
| outSnoop | output | 1 | Request must be snooped |
| outUr | output | 1 | Unsupported request |
| outFailCpl | output | 1 | Read must complete unsuccessfully |
| outAddr | output | 32 | Forwarded address |
| outBe | output | 4 | Forwarded byte enables |

## Verification
Every decision is due on the first falling edge after the rising edge that accepted its descriptor. The driver checks outValid at exactly that falling edge. The scoreboard monitor compares the full decision at the falling edge before the rising edge that hands it off. A configuration write takes effect on its own edge, so the request that follows it already sees the new value. Under back-pressure the bench holds outReady low for several cycles and checks each one to confirm the decision and inReady hold.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

  typedef enum logic [1:0] {
    KIND_RD   = 2'd0,
    KIND_WR   = 2'd1,
    KIND_MSG  = 2'd2,
    KIND_RSVD = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    DST_NONE = 3'd0,
    DST_DRAM = 3'd1,
    DST_GFX  = 3'd2,
    DST_PEER = 3'd3,
    DST_INT  = 3'd4
  } dest_e;

  // window indices; window w uses selectors 2+2w (base) and 3+2w (limit)
  localparam int WIN_AP   = 0;
  localparam int WIN_PEER = 1;
  localparam int WIN_SB   = 2;
  localparam int NUM_WIN  = 3;

  localparam logic [2:0] SEL_DRAM_TOP = 3'd0;
  localparam logic [2:0] SEL_CONTROL  = 3'd1;

  typedef struct packed {
    logic  dramHit;
    logic  apHit;
    logic  peerHit;
    logic  sbHit;
    logic  peerOwnSrc;
  } winHit_t;

  typedef struct packed {
    logic  load;
    dest_e dest;
    logic  snoop;
    logic  ur;
    logic  failCpl;
    logic  redirect;
    logic  killBe;
  } ctrlStrobe_t;

endpackage

// File: rtl/rtr_datapath.sv
module rtr_datapath
  import rtr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W = 4,
  parameter int PORT_W = 2,
  parameter logic [ADDR_W-1:0] LEGACY_ADDR = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [BE_W-1:0]   inBe,
  input  logic [PORT_W-1:0] inSrcPort,
  input  ctrlStrobe_t       strobe,
  output winHit_t           hits,
  output logic              bmeOn,
  output dest_e             outDest,
  output logic              outSnoop,
  output logic              outUr,
  output logic              outFailCpl,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BE_W-1:0]   outBe
);

  localparam int CTRL_W = PORT_W + 1;

  logic [ADDR_W-1:0] dramTop;
  logic [CTRL_W-1:0] ctrlReg;
  logic [ADDR_W-1:0] winBase  [NUM_WIN];
  logic [ADDR_W-1:0] winLimit [NUM_WIN];
  logic [NUM_WIN-1:0] winHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramTop <= '0;
      ctrlReg <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel == SEL_DRAM_TOP) dramTop <= cfgData;
      if (cfgSel == SEL_CONTROL)  ctrlReg <= cfgData[CTRL_W-1:0];
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [2:0] SEL_BASE  = 3'(2 + 2 * w);
    localparam logic [2:0] SEL_LIMIT = 3'(3 + 2 * w);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        winBase[w]  <= '1;
        winLimit[w] <= '0;
      end else if (cfgWrEn) begin
        if (cfgSel == SEL_BASE)  winBase[w]  <= cfgData;
        if (cfgSel == SEL_LIMIT) winLimit[w] <= cfgData;
      end
    end
    assign winHit[w] = (inAddr >= winBase[w]) && (inAddr <= winLimit[w]);
  end

  assign bmeOn = ctrlReg[0];

  always_comb begin
    hits.dramHit    = inAddr < dramTop;
    hits.apHit      = winHit[WIN_AP];
    hits.peerHit    = winHit[WIN_PEER];
    hits.sbHit      = winHit[WIN_SB];
    hits.peerOwnSrc = ctrlReg[CTRL_W-1:1] == inSrcPort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outDest    <= DST_NONE;
      outSnoop   <= 1'b0;
      outUr      <= 1'b0;
      outFailCpl <= 1'b0;
      outAddr    <= '0;
      outBe      <= '0;
    end else if (strobe.load) begin
      outDest    <= strobe.dest;
      outSnoop   <= strobe.snoop;
      outUr      <= strobe.ur;
      outFailCpl <= strobe.failCpl;
      outAddr    <= strobe.redirect ? LEGACY_ADDR : inAddr;
      outBe      <= strobe.killBe ? '0 : inBe;
    end
  end

endmodule

// File: rtl/rtr_ctrl.sv
module rtr_ctrl
  import rtr_pkg::*;
#(
  parameter int VC_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      inKind,
  input  logic [VC_W-1:0] inVc,
  input  logic            inNoSnoop,
  input  winHit_t         hits,
  input  logic            bmeOn,
  input  logic            outReady,
  output logic            inReady,
  output logic            outValid,
  output ctrlStrobe_t     strobe
);

  reqKind_e kind;
  logic     isRd;
  logic     isWr;

  assign kind    = reqKind_e'(inKind);
  assign isRd    = kind == KIND_RD;
  assign isWr    = kind == KIND_WR;
  assign inReady = !outValid || outReady;

  always_comb begin
    strobe          = '0;
    strobe.load     = inValid && inReady;
    strobe.dest     = DST_NONE;
    if (!bmeOn) begin
      strobe.ur = 1'b1;
    end else if (inVc != '0 || kind == KIND_RSVD) begin
      strobe.ur = 1'b1;
    end else if (kind == KIND_MSG) begin
      strobe.dest = DST_INT;
    end else if (hits.apHit) begin
      if (isWr) strobe.dest = DST_GFX;
      else      strobe.ur   = 1'b1;
    end else if (hits.sbHit) begin
      strobe.ur = 1'b1;
    end else if (hits.peerHit) begin
      if (isWr && !hits.peerOwnSrc) strobe.dest = DST_PEER;
      else                          strobe.ur   = 1'b1;
    end else if (hits.dramHit) begin
      strobe.dest  = DST_DRAM;
      strobe.snoop = !inNoSnoop;
    end else if (inNoSnoop) begin
      strobe.dest     = DST_DRAM;
      strobe.redirect = 1'b1;
      strobe.failCpl  = isRd;
      strobe.killBe   = isWr;
    end else begin
      strobe.ur = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outValid <= 1'b0;
    else if (strobe.load) outValid <= 1'b1;
    else if (outReady)    outValid <= 1'b0;
  end

endmodule

// File: rtl/pcie_inbound_router.sv
module pcie_inbound_router
  import rtr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W = 4,
  parameter int VC_W = 3,
  parameter int PORT_W = 2,
  parameter logic [ADDR_W-1:0] LEGACY_ADDR = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inKind,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [BE_W-1:0]   inBe,
  input  logic [VC_W-1:0]   inVc,
  input  logic              inNoSnoop,
  input  logic [PORT_W-1:0] inSrcPort,
  output logic              outValid,
  input  logic              outReady,
  output logic [2:0]        outDest,
  output logic              outSnoop,
  output logic              outUr,
  output logic              outFailCpl,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BE_W-1:0]   outBe
);

  winHit_t     hits;
  ctrlStrobe_t strobe;
  logic        bmeOn;
  dest_e       destQ;

  rtr_ctrl #(.VC_W(VC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKind(inKind), .inVc(inVc),
    .inNoSnoop(inNoSnoop), .hits(hits), .bmeOn(bmeOn), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  rtr_datapath #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .PORT_W(PORT_W), .LEGACY_ADDR(LEGACY_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .inAddr(inAddr), .inBe(inBe), .inSrcPort(inSrcPort), .strobe(strobe),
    .hits(hits), .bmeOn(bmeOn), .outDest(destQ), .outSnoop(outSnoop),
    .outUr(outUr), .outFailCpl(outFailCpl), .outAddr(outAddr), .outBe(outBe)
  );

  assign outDest = destQ;

endmodule

// File: rtl/rtr_checker.sv
module rtr_checker #(
  parameter int ADDR_W = 32,
  parameter int BE_W = 4,
  parameter int VC_W = 3,
  parameter logic [ADDR_W-1:0] LEGACY_ADDR = 32'h000C_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [1:0]        inKind,
  input logic [VC_W-1:0]   inVc,
  input logic              bmeOn,
  input logic              outValid,
  input logic              outReady,
  input logic [2:0]        outDest,
  input logic              outSnoop,
  input logic              outUr,
  input logic              outFailCpl,
  input logic [ADDR_W-1:0] outAddr,
  input logic [BE_W-1:0]   outBe
);

  logic fire;
  assign fire = inValid && inReady;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> outValid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outBe)
                                 && $stable(outDest) && $stable(outUr)));

  assert_bme_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !bmeOn) |=> outUr);

  assert_channel_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fire && inVc != '0) |=> outUr);

  assert_message_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fire && bmeOn && inVc == '0 && inKind == 2'd2) |=>
      (outDest == 3'd4 && !outSnoop && !outUr));

  assert_redirect_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFailCpl) |-> (outAddr == LEGACY_ADDR && !outSnoop && outDest == 3'd1));

  assert_unsupported_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUr) |-> (outDest == 3'd0 && !outSnoop && !outFailCpl));

endmodule

bind pcie_inbound_router rtr_checker #(
  .ADDR_W(ADDR_W), .BE_W(BE_W), .VC_W(VC_W), .LEGACY_ADDR(LEGACY_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inKind(inKind),
  .inVc(inVc), .bmeOn(bmeOn), .outValid(outValid), .outReady(outReady),
  .outDest(outDest), .outSnoop(outSnoop), .outUr(outUr), .outFailCpl(outFailCpl),
  .outAddr(outAddr), .outBe(outBe)
);

// File: tb/pcie_inbound_router_tb.sv
module pcie_inbound_router_tb;

  localparam logic [31:0] LEGACY = 32'h000C_0000;

  typedef struct packed {
    logic [2:0]  dest;
    logic        snoop;
    logic        ur;
    logic        fail;
    logic [31:0] addr;
    logic [3:0]  be;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] inKind = '0;
  logic [31:0] inAddr = '0;
  logic [3:0] inBe = '0;
  logic [2:0] inVc = '0;
  logic inNoSnoop = 1'b0;
  logic [1:0] inSrcPort = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [2:0] outDest;
  logic outSnoop, outUr, outFailCpl;
  logic [31:0] outAddr;
  logic [3:0] outBe;

  int checks = 0;
  int errors = 0;
  exp_t expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  pcie_inbound_router u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .inValid(inValid), .inReady(inReady), .inKind(inKind), .inAddr(inAddr),
    .inBe(inBe), .inVc(inVc), .inNoSnoop(inNoSnoop), .inSrcPort(inSrcPort),
    .outValid(outValid), .outReady(outReady), .outDest(outDest), .outSnoop(outSnoop),
    .outUr(outUr), .outFailCpl(outFailCpl), .outAddr(outAddr), .outBe(outBe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor: compare the decision at the falling edge before it is handed off
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      exp_t got;
      got = '{dest: outDest, snoop: outSnoop, ur: outUr, fail: outFailCpl,
              addr: outAddr, be: outBe};
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "unexpected decision", 64'(got), 64'd0);
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(got == e, t, "decision {dest,snoop,ur,fail,addr,be}", 64'(got), 64'(e));
      end
    end
  end

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgSel = sel;
    cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic send(input logic [1:0] kind, input logic [31:0] addr, input logic [3:0] be,
                      input logic [2:0] vc, input logic ns, input logic [1:0] src,
                      input logic [2:0] eDest, input logic eSnoop, input logic eUr,
                      input logic eFail, input logic [31:0] eAddr, input logic [3:0] eBe,
                      input string tag);
    @(negedge clk);
    inKind = kind; inAddr = addr; inBe = be; inVc = vc; inNoSnoop = ns; inSrcPort = src;
    inValid = 1'b1;
    expQ.push_back('{dest: eDest, snoop: eSnoop, ur: eUr, fail: eFail, addr: eAddr, be: eBe});
    tagQ.push_back(tag);
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, "R1", "outValid one cycle after accept", 64'(outValid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1", "reset outValid", 64'(outValid), 64'd0);
    check(inReady === 1'b1, "R1", "reset inReady", 64'(inReady), 64'd1);

    // R13: program windows; control last
    cfgWrite(3'd0, 32'h4000_0000);
    cfgWrite(3'd2, 32'h8000_0000); cfgWrite(3'd3, 32'h8FFF_FFFF);
    cfgWrite(3'd4, 32'h9000_0000); cfgWrite(3'd5, 32'h90FF_FFFF);
    cfgWrite(3'd6, 32'hA000_0000); cfgWrite(3'd7, 32'hA0FF_FFFF);

    // R2: bus mastering disabled
    send(2'd0, 32'h0000_1000, 4'hF, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0000_1000, 4'hF, "R2");
    send(2'd2, 32'hFEE0_0000, 4'hF, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'hFEE0_0000, 4'hF, "R2");

    cfgWrite(3'd1, 32'h0000_0003); // enable, peer owned by port 1

    // R8
    send(2'd0, 32'h0000_1000, 4'hF, 3'd0, 1'b0, 2'd0, 3'd1, 1'b1, 1'b0, 1'b0, 32'h0000_1000, 4'hF, "R8");
    send(2'd1, 32'h3FFF_FFF0, 4'h3, 3'd0, 1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h3FFF_FFF0, 4'h3, "R8");
    // R3
    send(2'd0, 32'h0000_1000, 4'hF, 3'd1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0000_1000, 4'hF, "R3");
    send(2'd1, 32'h0000_2000, 4'hF, 3'd7, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0000_2000, 4'hF, "R3");
    send(2'd3, 32'h0000_2000, 4'hF, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0000_2000, 4'hF, "R3");
    // R12: channel beats message
    send(2'd2, 32'hFEE0_0000, 4'hF, 3'd1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'hFEE0_0000, 4'hF, "R12");
    // R4
    send(2'd2, 32'hFEE0_0000, 4'hF, 3'd0, 1'b1, 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 32'hFEE0_0000, 4'hF, "R4");
    // R12: message inside aperture still to interrupt
    send(2'd2, 32'h8000_0100, 4'hF, 3'd0, 1'b0, 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 32'h8000_0100, 4'hF, "R12");
    // R5
    send(2'd1, 32'h8000_0000, 4'hF, 3'd0, 1'b0, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 4'hF, "R5");
    send(2'd1, 32'h8FFF_FFFF, 4'h1, 3'd0, 1'b1, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 32'h8FFF_FFFF, 4'h1, "R5");
    send(2'd0, 32'h8000_0040, 4'hF, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0040, 4'hF, "R5");
    // R6
    send(2'd1, 32'h9000_0010, 4'hF, 3'd0, 1'b0, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 32'h9000_0010, 4'hF, "R6");
    send(2'd1, 32'h90FF_FFFF, 4'hF, 3'd0, 1'b0, 2'd1, 3'd0, 1'b0, 1'b1, 1'b0, 32'h90FF_FFFF, 4'hF, "R6");
    send(2'd0, 32'h9000_0010, 4'hF, 3'd0, 1'b0, 2'd2, 3'd0, 1'b0, 1'b1, 1'b0, 32'h9000_0010, 4'hF, "R6");
    // R7
    send(2'd1, 32'hA000_0000, 4'hF, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'hA000_0000, 4'hF, "R7");
    // R9
    send(2'd0, 32'hB000_0000, 4'h5, 3'd0, 1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b1, LEGACY, 4'h5, "R9");
    // R10
    send(2'd1, 32'h4000_0000, 4'hF, 3'd0, 1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, LEGACY, 4'h0, "R10");
    // R11
    send(2'd1, 32'hC000_0000, 4'h6, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'hC000_0000, 4'h6, "R11");
    send(2'd0, 32'h4000_0000, 4'h9, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h4000_0000, 4'h9, "R11");

    // R13: lower DRAM top and move peer ownership to port 0
    cfgWrite(3'd0, 32'h0000_1000);
    cfgWrite(3'd1, 32'h0000_0001);
    send(2'd0, 32'h0000_1000, 4'hF, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0000_1000, 4'hF, "R13");
    send(2'd1, 32'h9000_0010, 4'hF, 3'd0, 1'b0, 2'd1, 3'd3, 1'b0, 1'b0, 1'b0, 32'h9000_0010, 4'hF, "R13");

    // R1: back-pressure holds the decision and blocks input
    @(posedge clk); #1 outReady = 1'b0;
    send(2'd0, 32'h0000_0800, 4'hF, 3'd0, 1'b0, 2'd0, 3'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0800, 4'hF, "R1");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid === 1'b1 && outAddr === 32'h0000_0800, "R1", "held decision",
            64'({outValid, outAddr}), 64'({1'b1, 32'h0000_0800}));
      check(inReady === 1'b0, "R1", "inReady under stall", 64'(inReady), 64'd0);
    end
    @(posedge clk); #1 outReady = 1'b1;
    send(2'd1, 32'h0000_0900, 4'hF, 3'd0, 1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0000_0900, 4'hF, "R1");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R1", "pending decisions", 64'(expQ.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule